// File: doc/BRIEF.md
# Configurable GPIO Port Register Bank

This block holds the software-visible state for a group of identical general purpose I/O ports. Each port has a byte-wide output latch, an input-mode register and an output-mode register. The input-mode register selects analog or digital operation for each pin. The output-mode register selects open-drain or push-pull drive. From this state the block produces three registered vectors for every pin: an output enable, a drive value and a weak-pullup enable. These vectors feed the pad cells.

A simple register port gives access to the state. A write is either byte-wide, using an address and data, or single-bit, using a port number, a bit index and a value. A read returns its data one cycle after the request. A qualifier on the read tells the block that the access is the read half of a read-modify-write. On such a read the block returns the latch contents instead of the pins, so the write-back does not copy external levels into the latch. Pin inputs pass through a synchronizer before they are read. A global input switches off every weak pullup.

The address is `{port_index, select}`. `select` 0 is the latch, 1 is the input mode and 2 is the output mode. `select` 3 and port indices at or above the port count are reserved.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every output latch is 0xFF, every input-mode register is 0xFF (all pins digital) and every output-mode register is 0x00 (all pins open-drain). Consequently no pin drives and all pullups are on.
- R2: A byte write to address `{p, s}` updates register `s` of port `p` at the next clock edge. A read places data on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_re`, and it returns the value from before any write in the same cycle. Select 3 and out-of-range ports read 0x00, and writes to them change nothing.
- R3: A single-bit write (`bit_we`, `bit_port`, `bit_idx`, `bit_val`) changes exactly the addressed latch bit.
- R4: When a byte write to a port's latch and a single-bit write to the same port fall in the same cycle, the single-bit write decides its bit and the byte write sets the others.
- R5: A normal read of select 0 returns the pin levels after a two-flop synchronizer. A pin change made just before a read is therefore not yet seen, but it is seen one cycle later. Bits of analog-mode pins (input-mode bit 0) read 0.
- R6: A read with `bus_rmw` high on select 0 returns the latch contents, not the pins.
- R7: A digital pin whose latch bit is 0 has `pin_oe`=1 and `pin_drv`=0.
- R8: A digital pin whose latch bit is 1 has `pin_oe`=1 and `pin_drv`=1 in push-pull mode (output-mode bit 1). In open-drain mode it has `pin_oe`=0, so it floats.
- R9: An analog-mode pin has `pin_oe`, `pin_drv` and `pin_pu` all 0, whatever its latch and output-mode bits are.
- R10: `pin_pu` is 1 for a digital pin that is not being driven low, as long as `pu_disable` is 0. `pu_disable`=1 clears `pin_pu` on every pin.
- R11: The pad outputs are registered and reflect the register state one clock after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Byte write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rmw | input | 1 | Read belongs to a read-modify-write |
| bus_addr | input | PIDX_W+2 | {port index, register select} |
| bus_wdata | input | PORT_W | Byte write data |
| bit_we | input | 1 | Single-bit latch write strobe |
| bit_port | input | PIDX_W | Port of the single-bit write |
| bit_idx | input | BIT_W | Bit of the single-bit write |
| bit_val | input | 1 | Value of the single-bit write |
| pu_disable | input | 1 | Global weak-pullup disable |
| pin_in | input | NUM_PORTS*PORT_W | Pin levels from the pads |
| bus_rdata | output | PORT_W | Read data |
| bus_rvalid | output | 1 | Read data valid |
| pin_oe | output | NUM_PORTS*PORT_W | Per-pin output enable |
| pin_drv | output | NUM_PORTS*PORT_W | Per-pin drive value |
| pin_pu | output | NUM_PORTS*PORT_W | Per-pin weak-pullup enable |

## Verification
Two kinds of access can land on the same latch in one cycle. The first is a byte write together with a single-bit write to the same port. The bench issues both from one stimulus cycle, then reads the latch back with a read-modify-write read and checks that the single-bit value wins on its bit. The second is a read together with a write to the same register. The bench expects the pre-write value from that read and the new value from the next one. Synchronizer latency gets the same treatment: a pin change is made right before a read, and the bench expects the old level from that read and the new level from the following one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH   = 2'd0,
    SEL_INMODE  = 2'd1,
    SEL_OUTMODE = 2'd2,
    SEL_RSVD    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter int W     = 8,
  localparam int BIT_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_we,
  input  reg_sel_e         sel,
  input  logic [W-1:0]     wdata,
  input  logic             bit_we,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             bit_val,
  input  logic             pu_disable,
  output logic [W-1:0]     latch_q,
  output logic [W-1:0]     inmode_q,
  output logic [W-1:0]     outmode_q,
  output logic [W-1:0]     oe_q,
  output logic [W-1:0]     drv_q,
  output logic [W-1:0]     pu_q
);
  logic [W-1:0] latch_nxt;
  logic [W-1:0] oe_c, drv_c, pu_c;
  logic         byte_to_latch;

  assign byte_to_latch = sel_we && (sel == SEL_LATCH);

  // byte write first, single-bit write overrides its own bit
  always_comb begin
    latch_nxt = latch_q;
    if (byte_to_latch) latch_nxt = wdata;
    if (bit_we) latch_nxt[bit_idx] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= '1;
      inmode_q  <= '1;
      outmode_q <= '0;
    end else begin
      latch_q <= latch_nxt;
      if (sel_we && sel == SEL_INMODE)  inmode_q  <= wdata;
      if (sel_we && sel == SEL_OUTMODE) outmode_q <= wdata;
    end
  end

  // pad control: analog pins are fully quiet
  assign oe_c  = inmode_q & (~latch_q | outmode_q);
  assign drv_c = inmode_q & latch_q & outmode_q;
  assign pu_c  = {W{~pu_disable}} & inmode_q & ~(oe_c & ~drv_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      drv_q <= '0;
      pu_q  <= '0;
    end else begin
      oe_q  <= oe_c;
      drv_q <= drv_c;
      pu_q  <= pu_c;
    end
  end

  AST_BIT_WRITE: assert property (@(posedge clk) disable iff (rst)
    bit_we |=> latch_q[$past(bit_idx)] == $past(bit_val)); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bit_we && !byte_to_latch) |=> $stable(latch_q)); // R3
  AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((oe_q | drv_q | pu_q) & ~$past(inmode_q)) == '0); // R9
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
    (oe_q & drv_q & ~$past(outmode_q)) == '0); // R8
  AST_PU_NOT_LOW: assert property (@(posedge clk) disable iff (rst)
    (pu_q & oe_q & ~drv_q) == '0); // R10
  AST_PU_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(pu_disable) |-> pu_q == '0); // R10
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS   = 3,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int BIT_W  = (PORT_W > 1) ? $clog2(PORT_W) : 1,
  localparam int ADDR_W = PIDX_W + 2,
  localparam int PINS   = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_rmw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic              bit_we,
  input  logic [PIDX_W-1:0] bit_port,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              bit_val,
  input  logic              pu_disable,
  input  logic [PINS-1:0]   pin_in,
  output logic [PORT_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_drv,
  output logic [PINS-1:0]   pin_pu
);
  logic [PIDX_W-1:0] addr_port;
  reg_sel_e          addr_sel;
  logic [PINS-1:0]   pin_s;
  logic [PORT_W-1:0] latch_a   [NUM_PORTS];
  logic [PORT_W-1:0] inmode_a  [NUM_PORTS];
  logic [PORT_W-1:0] outmode_a [NUM_PORTS];
  logic [PORT_W-1:0] sel_latch, sel_inmode, rd_c;

  assign addr_port = bus_addr[ADDR_W-1:2];
  assign addr_sel  = reg_sel_e'(bus_addr[1:0]);

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    gpio_port #(.W(PORT_W)) u_port (
      .clk        (clk),
      .rst        (rst),
      .sel_we     (bus_we && (addr_port == PIDX_W'(i))),
      .sel        (addr_sel),
      .wdata      (bus_wdata),
      .bit_we     (bit_we && (bit_port == PIDX_W'(i))),
      .bit_idx    (bit_idx),
      .bit_val    (bit_val),
      .pu_disable (pu_disable),
      .latch_q    (latch_a[i]),
      .inmode_q   (inmode_a[i]),
      .outmode_q  (outmode_a[i]),
      .oe_q       (pin_oe[i*PORT_W +: PORT_W]),
      .drv_q      (pin_drv[i*PORT_W +: PORT_W]),
      .pu_q       (pin_pu[i*PORT_W +: PORT_W])
    );
  end

  always_comb begin
    sel_latch  = '0;
    sel_inmode = '0;
    rd_c       = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (addr_port == PIDX_W'(i)) begin
        sel_latch  = latch_a[i];
        sel_inmode = inmode_a[i];
        case (addr_sel)
          SEL_LATCH:   rd_c = bus_rmw ? latch_a[i]
                                      : (pin_s[i*PORT_W +: PORT_W] & inmode_a[i]);
          SEL_INMODE:  rd_c = inmode_a[i];
          SEL_OUTMODE: rd_c = outmode_a[i];
          default:     rd_c = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) bus_rdata <= rd_c;
    end
  end

  AST_RD_ANALOG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !bus_rmw && addr_sel == SEL_LATCH)
      |=> (bus_rdata & ~$past(sel_inmode)) == '0); // R5
  AST_RMW_RETURNS_LATCH: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_rmw && addr_sel == SEL_LATCH)
      |=> bus_rdata == $past(sel_latch)); // R6
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> bus_rvalid); // R2
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 0, bus_re = 0, bus_rmw = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bit_we = 0;
  logic [1:0] bit_port = '0;
  logic [2:0] bit_idx = '0;
  logic bit_val = 0;
  logic pu_disable = 0;
  logic [NP*PW-1:0] pin_in = '0;
  logic [7:0] bus_rdata;
  logic bus_rvalid;
  logic [NP*PW-1:0] pin_oe, pin_drv, pin_pu;

  int checks = 0;
  int errors = 0;
  string      q_tag[$];
  logic [7:0] q_exp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.NUM_PORTS(NP), .PORT_W(PW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_rmw(bus_rmw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bit_we(bit_we), .bit_port(bit_port),
    .bit_idx(bit_idx), .bit_val(bit_val), .pu_disable(pu_disable), .pin_in(pin_in),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pin_oe(pin_oe),
    .pin_drv(pin_drv), .pin_pu(pin_pu)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one stimulus cycle: drive at a falling edge, release at the next
  task automatic access(input logic we, input logic re, input logic rmw,
                        input logic [1:0] port, input logic [1:0] sel,
                        input logic [7:0] wd, input logic bwe, input logic [1:0] bport,
                        input logic [2:0] bidx, input logic bval,
                        input string tag, input logic [7:0] exp);
    @(negedge clk);
    if (re) begin q_tag.push_back(tag); q_exp.push_back(exp); end
    bus_we = we; bus_re = re; bus_rmw = rmw; bus_addr = {port, sel};
    bus_wdata = wd; bit_we = bwe; bit_port = bport; bit_idx = bidx; bit_val = bval;
    @(negedge clk);
    bus_we = 0; bus_re = 0; bus_rmw = 0; bit_we = 0;
  endtask

  task automatic wr(input logic [1:0] port, input logic [1:0] sel, input logic [7:0] wd);
    access(1, 0, 0, port, sel, wd, 0, 0, 0, 0, "", 8'h00);
  endtask

  task automatic rd(input logic [1:0] port, input logic [1:0] sel, input logic rmw,
                    input string tag, input logic [7:0] exp);
    access(0, 1, rmw, port, sel, 8'h00, 0, 0, 0, 0, tag, exp);
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (q_exp.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected rvalid actual=%02h expected=none", bus_rdata);
      end else begin
        chk(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    for (int p = 0; p < NP; p++) begin
      chk("R1 oe",  pin_oe[p*PW +: PW], 8'h00);
      chk("R1 drv", pin_drv[p*PW +: PW], 8'h00);
      chk("R1 pu",  pin_pu[p*PW +: PW], 8'hFF);
    end
    rd(0, 1, 0, "R1 inmode", 8'hFF);
    rd(0, 2, 0, "R1 outmode", 8'h00);
    rd(0, 0, 1, "R1 latch", 8'hFF);

    // R5 normal read of digital pins
    pin_in[7:0] = 8'hA5;
    repeat (3) @(negedge clk);
    rd(0, 0, 0, "R5 pins digital", 8'hA5);

    // R2 write/read of mode register; R7 R8 R10 R11 pad control
    wr(0, 2, 8'h0F);
    rd(0, 2, 0, "R2 outmode readback", 8'h0F);
    wr(0, 0, 8'h3C);
    chk("R11 oe not yet updated", pin_oe[7:0], 8'hFF & 8'h0F | 8'h00);
    @(negedge clk);
    chk("R7 R8 oe", pin_oe[7:0], 8'hCF);
    chk("R8 drv push-pull high", pin_drv[7:0], 8'h0C);
    chk("R10 pu", pin_pu[7:0], 8'h3C);

    // R9 analog low nibble
    wr(0, 1, 8'hF0);
    @(negedge clk);
    chk("R9 oe", pin_oe[7:0], 8'hC0);
    chk("R9 drv", pin_drv[7:0], 8'h00);
    chk("R9 pu", pin_pu[7:0], 8'h30);
    rd(0, 0, 0, "R5 analog reads zero", 8'hA0);
    rd(0, 0, 1, "R6 rmw returns latch", 8'h3C);

    // R10 global pullup disable
    pu_disable = 1;
    @(negedge clk); @(negedge clk);
    chk("R10 pud port0", pin_pu[7:0], 8'h00);
    chk("R10 pud port2", pin_pu[23:16], 8'h00);
    pu_disable = 0;
    @(negedge clk); @(negedge clk);
    chk("R10 pud released", pin_pu[23:16], 8'hFF);

    // R3 single-bit write
    access(0, 0, 0, 0, 0, 8'h00, 1, 2, 3, 0, "", 8'h00);
    rd(2, 0, 1, "R3 bit write", 8'hF7);
    rd(1, 0, 1, "R3 other port untouched", 8'hFF);
    chk("R7 port2 oe", pin_oe[23:16], 8'h08);

    // R4 byte and bit write same cycle, same port
    access(1, 0, 0, 2, 0, 8'h00, 1, 2, 5, 1, "", 8'h00);
    rd(2, 0, 1, "R4 bit wins", 8'h20);
    chk("R4 port2 oe", pin_oe[23:16], 8'hDF);

    // R2 read and write same cycle
    access(1, 1, 1, 1, 0, 8'h55, 0, 0, 0, 0, "R2 read sees old", 8'hFF);
    rd(1, 0, 1, "R2 read sees new", 8'h55);
    // R2 reserved select and out-of-range port
    wr(1, 3, 8'hAA);
    rd(1, 3, 0, "R2 reserved select", 8'h00);
    wr(3, 0, 8'h00);
    rd(3, 0, 1, "R2 invalid port", 8'h00);
    rd(1, 0, 1, "R2 reserved write ignored", 8'h55);

    // R5 synchronizer latency
    pin_in[15:8] = 8'h5A;
    rd(1, 0, 0, "R5 sync old level", 8'h00);
    rd(1, 0, 0, "R5 sync new level", 8'h5A);

    repeat (3) @(negedge clk);
    if (q_exp.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing read data actual=%0d expected=0", q_exp.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule